// File: doc/BRIEF.md
# Selectable Configuration Output Multiplexer

This block drives a set of open-drain configuration outputs. Five of them are "muxed" outputs, and a sixth is a "side" output with a latch of its own. Each muxed output carries one of two values: a bit from an external default input bus, or a bit from a stored non-volatile configuration word. The sixth stored bit reaches the side output through a latch. That latch is transparent while stored data is selected and keeps its value otherwise.

After reset the choice follows an external select pin. A two-bit control register, written by the serial-bus engine on its acknowledge strobe, can take the choice away from the pin. An active-low override forces the outputs low, but only while stored data is selected. A program-busy flag freezes the internal copy of the stored word, so the outputs keep their old values until a reprogramming cycle completes.

The select pin passes through a synchronizer and is then turned into registered state. The design centres on a four-state selection machine:
- `SRC_PIN_EXT`: pin mode, external inputs selected.
- `SRC_PIN_NV`: pin mode, stored bits selected.
- `SRC_REG_EXT`: register mode, external inputs selected.
- `SRC_REG_NV`: register mode, stored bits selected.

The machine has six transitions:
- pin-low: the synchronized pin is 0 in pin mode, giving `SRC_PIN_NV`.
- pin-high: the synchronized pin is 1 in pin mode, giving `SRC_PIN_EXT`.
- handover: control bit 1 is set, giving a `SRC_REG_*` state.
- release: control bit 1 is cleared, giving a `SRC_PIN_*` state.
- reg-to-stored: control bit 0 is set in register mode, giving `SRC_REG_NV`.
- reg-to-external: control bit 0 is cleared in register mode, giving `SRC_REG_EXT`.

Top module: `cfgmux_top`

## Requirements
- R1: In pin mode with `sel_pin` at 0, `mux_val` equals `nv_bits[4:0]` and `side_val` follows `nv_bits[5]`. Both are visible at most 3 clock edges after the pin change.
- R2: In pin mode with `sel_pin` at 1, `mux_val` equals `ext_in`. Once that selection is in place, changes on `ext_in` pass through without a clock edge.
- R3: In pin mode the side latch is transparent while the synchronized pin is 0. It keeps the stored bit present at the rising edge of the pin. Later changes of `nv_bits[5]` do not reach `side_val` while the pin stays 1.
- R4: A pulse on `ctl_ack_stb` loads `ctl_wr_bits` into the control register. When bit 1 of the register is 1, `sel_pin` is ignored and bit 0 selects the source: 1 selects the stored bits and 0 selects `ext_in`. The new selection shows 2 clock edges after the strobe edge.
- R5: In register mode the side latch captures `nv_bits[5]` at the acknowledge of a control write that takes bit 1 from 0 to 1. A write that leaves bit 1 at 1 captures nothing. While the external inputs are selected in register mode, the side latch holds.
- R6: When `force_low_n` is 0 and stored data is selected, all muxed outputs and the side output read 0.
- R7: When the external inputs are selected, `force_low_n` has no effect on `mux_val` or `side_val`.
- R8: While `prog_busy` is 1, the internal copy of `nv_bits` is frozen and the outputs keep their values. The copy follows `nv_bits` again one clock edge after `prog_busy` returns to 0.
- R9: During reset the control register is 00 (pin mode), the state is `SRC_PIN_EXT`, `mux_val` equals `ext_in` and `side_val` is 0.
- R10: Each output is open-drain: the pull-down enable is the inverse of the logical value (`mux_pd_en == ~mux_val`, `side_pd_en == ~side_val`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_pin | input | 1 | External source select: 0 selects stored bits, 1 selects external inputs (pin mode) |
| force_low_n | input | 1 | Active-low override that forces the outputs low while stored data is selected |
| ext_in | input | EXT_W (5) | External default inputs |
| nv_bits | input | EXT_W+1 (6) | Stored configuration word; the top bit feeds the side output |
| ctl_ack_stb | input | 1 | One-cycle strobe at the bus acknowledge of a control register write |
| ctl_wr_bits | input | 2 | Control write data: bit 1 selects register mode, bit 0 selects stored (1) or external (0) |
| prog_busy | input | 1 | High while the stored configuration is being reprogrammed |
| mux_val | output | EXT_W (5) | Logical value of the muxed outputs |
| mux_pd_en | output | EXT_W (5) | Pull-down enables of the muxed outputs |
| side_val | output | 1 | Logical value of the side output |
| side_pd_en | output | 1 | Pull-down enable of the side output |

## Verification
Four properties are checked on every cycle:
- the override zeroes every output while stored data is selected;
- the external inputs pass straight through whenever they are selected;
- the stored copy cannot change during a programming cycle;
- a control write that sets the mode bit always moves the machine into a register-mode state.

Only the directed scenarios can show the following:
- the latency from the pin and the strobe;
- the difference between the transparent and the holding phases of the side latch;
- the capture on the 0-to-1 change of the mode bit;
- the pin being ignored in register mode.

// File: rtl/cfgmux_pkg.sv
package cfgmux_pkg;

    // bit 1: register mode, bit 0: stored data selected
    typedef enum logic [1:0] {
        SRC_PIN_EXT = 2'b00,
        SRC_PIN_NV  = 2'b01,
        SRC_REG_EXT = 2'b10,
        SRC_REG_NV  = 2'b11
    } src_state_e;

    localparam int CTL_W       = 2;
    localparam int CTL_MODE_BIT = 1;
    localparam int CTL_SRC_BIT  = 0;

endpackage

// File: rtl/cfgmux_sync.sv
module cfgmux_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= d_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign d_sync = chain[STAGES-1];

endmodule

// File: rtl/cfgmux_ctrl.sv
module cfgmux_ctrl
    import cfgmux_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_sync,
    input  logic             ack_stb,
    input  logic [CTL_W-1:0] wr_bits,
    output src_state_e       state,
    output logic             stored_sel,
    output logic             side_load
);
    logic [CTL_W-1:0] ctl_q;
    logic             pin_prev;
    logic             pin_rise;
    logic             reg_capture;
    logic             pin_mode;
    logic             side_follow;
    src_state_e       state_nxt;

    // control register, written at the bus acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ctl_q <= '0;
        else if (ack_stb) ctl_q <= wr_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_prev <= 1'b0;
        else        pin_prev <= pin_sync;
    end

    assign pin_rise    = pin_sync & ~pin_prev;
    assign reg_capture = ack_stb & wr_bits[CTL_MODE_BIT] & ~ctl_q[CTL_MODE_BIT];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SRC_PIN_EXT;
        else        state <= state_nxt;
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            SRC_PIN_EXT: begin
                if (ctl_q[CTL_MODE_BIT])
                    state_nxt = ctl_q[CTL_SRC_BIT] ? SRC_REG_NV : SRC_REG_EXT; // handover
                else if (!pin_sync)
                    state_nxt = SRC_PIN_NV;                                   // pin-low
            end
            SRC_PIN_NV: begin
                if (ctl_q[CTL_MODE_BIT])
                    state_nxt = ctl_q[CTL_SRC_BIT] ? SRC_REG_NV : SRC_REG_EXT; // handover
                else if (pin_sync)
                    state_nxt = SRC_PIN_EXT;                                  // pin-high
            end
            SRC_REG_EXT: begin
                if (!ctl_q[CTL_MODE_BIT])
                    state_nxt = pin_sync ? SRC_PIN_EXT : SRC_PIN_NV;          // release
                else if (ctl_q[CTL_SRC_BIT])
                    state_nxt = SRC_REG_NV;                                   // reg-to-stored
            end
            SRC_REG_NV: begin
                if (!ctl_q[CTL_MODE_BIT])
                    state_nxt = pin_sync ? SRC_PIN_EXT : SRC_PIN_NV;          // release
                else if (!ctl_q[CTL_SRC_BIT])
                    state_nxt = SRC_REG_EXT;                                  // reg-to-external
            end
            default: state_nxt = SRC_PIN_EXT;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        pin_mode    = 1'b1;
        stored_sel  = 1'b0;
        side_follow = 1'b0;
        unique case (state)
            SRC_PIN_EXT: begin pin_mode = 1'b1; stored_sel = 1'b0; side_follow = 1'b0; end
            SRC_PIN_NV:  begin pin_mode = 1'b1; stored_sel = 1'b1; side_follow = 1'b0; end
            SRC_REG_EXT: begin pin_mode = 1'b0; stored_sel = 1'b0; side_follow = 1'b0; end
            SRC_REG_NV:  begin pin_mode = 1'b0; stored_sel = 1'b1; side_follow = 1'b1; end
            default:     begin pin_mode = 1'b1; stored_sel = 1'b0; side_follow = 1'b0; end
        endcase
    end

    // side latch: transparent while the synchronized pin is low, captures on
    // its rise in pin mode; captures on the mode-bit set in register mode
    assign side_load = reg_capture | side_follow |
                       (pin_mode & (~pin_sync | pin_rise));

endmodule

// File: rtl/cfgmux_store.sv
module cfgmux_store #(
    parameter int NV_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NV_W-1:0] nv_bits,
    input  logic            prog_busy,
    input  logic            side_load,
    output logic [NV_W-1:0] held_bits,
    output logic            side_q
);
    // working copy of the stored word, frozen during programming
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          held_bits <= '0;
        else if (!prog_busy) held_bits <= nv_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         side_q <= 1'b0;
        else if (side_load) side_q <= held_bits[NV_W-1];
    end

endmodule

// File: rtl/cfgmux_drive.sv
module cfgmux_drive #(
    parameter int EXT_W = 5
) (
    input  logic             stored_sel,
    input  logic             force_low_n,
    input  logic [EXT_W-1:0] ext_in,
    input  logic [EXT_W-1:0] held_low,
    input  logic             side_q,
    output logic [EXT_W-1:0] mux_val,
    output logic [EXT_W-1:0] mux_pd_en,
    output logic             side_val,
    output logic             side_pd_en
);
    logic forced;

    assign forced = stored_sel & ~force_low_n;

    generate
        for (genvar b = 0; b < EXT_W; b++) begin : g_bit
            always_comb begin
                if (!stored_sel)  mux_val[b] = ext_in[b];
                else if (forced)  mux_val[b] = 1'b0;
                else              mux_val[b] = held_low[b];
            end
            assign mux_pd_en[b] = ~mux_val[b];
        end
    endgenerate

    assign side_val   = forced ? 1'b0 : side_q;
    assign side_pd_en = ~side_val;

endmodule

// File: rtl/cfgmux_top.sv
module cfgmux_top
    import cfgmux_pkg::*;
#(
    parameter int EXT_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_pin,
    input  logic             force_low_n,
    input  logic [EXT_W-1:0] ext_in,
    input  logic [EXT_W:0]   nv_bits,
    input  logic             ctl_ack_stb,
    input  logic [1:0]       ctl_wr_bits,
    input  logic             prog_busy,
    output logic [EXT_W-1:0] mux_val,
    output logic [EXT_W-1:0] mux_pd_en,
    output logic             side_val,
    output logic             side_pd_en
);
    localparam int NV_W = EXT_W + 1;

    logic            pin_sync;
    src_state_e      state;
    logic            stored_sel;
    logic            side_load;
    logic [NV_W-1:0] held_bits;
    logic            side_q;

    cfgmux_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_in   (sel_pin),
        .d_sync (pin_sync)
    );

    cfgmux_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_sync   (pin_sync),
        .ack_stb    (ctl_ack_stb),
        .wr_bits    (ctl_wr_bits),
        .state      (state),
        .stored_sel (stored_sel),
        .side_load  (side_load)
    );

    cfgmux_store #(.NV_W(NV_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .nv_bits   (nv_bits),
        .prog_busy (prog_busy),
        .side_load (side_load),
        .held_bits (held_bits),
        .side_q    (side_q)
    );

    cfgmux_drive #(.EXT_W(EXT_W)) u_drive (
        .stored_sel  (stored_sel),
        .force_low_n (force_low_n),
        .ext_in      (ext_in),
        .held_low    (held_bits[EXT_W-1:0]),
        .side_q      (side_q),
        .mux_val     (mux_val),
        .mux_pd_en   (mux_pd_en),
        .side_val    (side_val),
        .side_pd_en  (side_pd_en)
    );

endmodule

// File: rtl/cfgmux_checker.sv
module cfgmux_checker #(
    parameter int EXT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             force_low_n,
    input logic [EXT_W-1:0] ext_in,
    input logic             ctl_ack_stb,
    input logic [1:0]       ctl_wr_bits,
    input logic             prog_busy,
    input logic [EXT_W-1:0] mux_val,
    input logic             side_val,
    input logic [1:0]       state_bits,
    input logic [EXT_W:0]   held_bits
);
    // R6: override zeroes every output while stored data is selected
    a_r6_override_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_low_n && state_bits[0]) |-> (mux_val == '0 && !side_val));

    // R7 / R2: external inputs pass straight through when selected
    a_r7_ext_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_bits[0]) |-> (mux_val == ext_in));

    // R8: stored copy cannot move while programming is in progress
    a_r8_frozen_copy: assert property (@(posedge clk) disable iff (!rst_n)
        $past(prog_busy) |-> $stable(held_bits));

    // R4: a write that sets the mode bit leads into a register-mode state
    a_r4_handover: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_ack_stb && ctl_wr_bits[1]) ##1 (!ctl_ack_stb) |=> state_bits[1]);

endmodule

bind cfgmux_top cfgmux_checker #(.EXT_W(EXT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .force_low_n (force_low_n),
    .ext_in      (ext_in),
    .ctl_ack_stb (ctl_ack_stb),
    .ctl_wr_bits (ctl_wr_bits),
    .prog_busy   (prog_busy),
    .mux_val     (mux_val),
    .side_val    (side_val),
    .state_bits  (state),
    .held_bits   (held_bits)
);

// File: tb/tb_cfgmux_top.sv
module tb_cfgmux_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel_pin;
    logic       force_low_n;
    logic [4:0] ext_in;
    logic [5:0] nv_bits;
    logic       ctl_ack_stb;
    logic [1:0] ctl_wr_bits;
    logic       prog_busy;
    logic [4:0] mux_val;
    logic [4:0] mux_pd_en;
    logic       side_val;
    logic       side_pd_en;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    cfgmux_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_pin     (sel_pin),
        .force_low_n (force_low_n),
        .ext_in      (ext_in),
        .nv_bits     (nv_bits),
        .ctl_ack_stb (ctl_ack_stb),
        .ctl_wr_bits (ctl_wr_bits),
        .prog_busy   (prog_busy),
        .mux_val     (mux_val),
        .mux_pd_en   (mux_pd_en),
        .side_val    (side_val),
        .side_pd_en  (side_pd_en)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl_write(input logic [1:0] bits);
        ctl_wr_bits = bits;
        ctl_ack_stb = 1'b1;
        tick(1);
        ctl_ack_stb = 1'b0;
        tick(1);
    endtask

    task automatic t_reset;
        rst_n = 1'b0; sel_pin = 1'b1; force_low_n = 1'b1; ext_in = 5'h0A;
        nv_bits = 6'h2D; ctl_ack_stb = 1'b0; ctl_wr_bits = 2'b00; prog_busy = 1'b0;
        tick(3);
        check("R9 mux in reset", {3'b0, mux_val}, 8'h0A);
        check("R9 side in reset", {7'b0, side_val}, 8'h00);
        rst_n = 1'b1;
        tick(4);
    endtask

    task automatic t_pin_stored;
        sel_pin = 1'b0;
        tick(3);
        check("R1 mux stored", {3'b0, mux_val}, 8'h0D);
        check("R1 side stored", {7'b0, side_val}, 8'h01);
        check("R10 mux pulldown", {3'b0, mux_pd_en}, 8'h12);
        check("R10 side pulldown", {7'b0, side_pd_en}, 8'h00);
        nv_bits = 6'h13;
        tick(2);
        check("R1 mux follows store", {3'b0, mux_val}, 8'h13);
        check("R3 side transparent", {7'b0, side_val}, 8'h00);
    endtask

    task automatic t_pin_ext;
        sel_pin = 1'b1;
        tick(3);
        check("R2 mux external", {3'b0, mux_val}, 8'h0A);
        ext_in = 5'h1F;
        #1;
        check("R2 ext passthrough", {3'b0, mux_val}, 8'h1F);
        tick(1);
    endtask

    task automatic t_side_latch;
        sel_pin = 1'b0; nv_bits = 6'h20;
        tick(3);
        check("R3 side open", {7'b0, side_val}, 8'h01);
        sel_pin = 1'b1;
        tick(3);
        check("R3 side after rise", {7'b0, side_val}, 8'h01);
        nv_bits = 6'h00;
        tick(2);
        check("R3 side holds", {7'b0, side_val}, 8'h01);
    endtask

    task automatic t_override;
        force_low_n = 1'b0;
        tick(1);
        check("R7 override ignored mux", {3'b0, mux_val}, 8'h1F);
        check("R7 override ignored side", {7'b0, side_val}, 8'h01);
        nv_bits = 6'h3F; sel_pin = 1'b0;
        tick(3);
        check("R6 override mux", {3'b0, mux_val}, 8'h00);
        check("R6 override side", {7'b0, side_val}, 8'h00);
        check("R10 forced pulldown", {3'b0, mux_pd_en}, 8'h1F);
        force_low_n = 1'b1;
        tick(1);
        check("R6 override released mux", {3'b0, mux_val}, 8'h1F);
        check("R6 override released side", {7'b0, side_val}, 8'h01);
    endtask

    task automatic t_reg_mode;
        ext_in = 5'h05;
        ctl_write(2'b10);
        check("R4 reg external", {3'b0, mux_val}, 8'h05);
        sel_pin = 1'b1;
        tick(3);
        check("R4 pin ignored high", {3'b0, mux_val}, 8'h05);
        sel_pin = 1'b0;
        tick(3);
        check("R4 pin ignored low", {3'b0, mux_val}, 8'h05);
        ctl_write(2'b11);
        check("R4 reg stored", {3'b0, mux_val}, 8'h1F);
    endtask

    task automatic t_reg_capture;
        ctl_write(2'b00);
        sel_pin = 1'b0;
        tick(3);
        nv_bits = 6'h20;
        tick(2);
        check("R5 side before", {7'b0, side_val}, 8'h01);
        sel_pin = 1'b1;
        tick(3);
        nv_bits = 6'h00;
        tick(2);
        check("R5 side held pin", {7'b0, side_val}, 8'h01);
        ctl_write(2'b10);
        check("R5 capture on mode set", {7'b0, side_val}, 8'h00);
        nv_bits = 6'h20;
        tick(2);
        check("R5 holds in reg ext", {7'b0, side_val}, 8'h00);
        ctl_write(2'b10);
        check("R5 no capture without rise", {7'b0, side_val}, 8'h00);
    endtask

    task automatic t_prog_hold;
        ctl_write(2'b11);
        nv_bits = 6'h0F;
        tick(2);
        check("R8 before busy", {3'b0, mux_val}, 8'h0F);
        prog_busy = 1'b1;
        nv_bits = 6'h30;
        tick(3);
        check("R8 mux frozen", {3'b0, mux_val}, 8'h0F);
        check("R8 side frozen", {7'b0, side_val}, 8'h00);
        prog_busy = 1'b0;
        tick(2);
        check("R8 mux after busy", {3'b0, mux_val}, 8'h10);
        check("R8 side after busy", {7'b0, side_val}, 8'h01);
    endtask

    initial begin
        t_reset();
        t_pin_stored();
        t_pin_ext();
        t_side_latch();
        t_override();
        t_reg_mode();
        t_reg_capture();
        t_prog_hold();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule